// File: doc/BRIEF.md
# Register Bank with Crossbar Bypass

This block couples a multi-ported register bank to a two-stage pipelined adder through a crossbar. The crossbar is a registered stage on both sides. On the read side, an accepted instruction spends its issue cycle fetching operands, and they are captured at the end of that cycle. On the write side, the sum spends one cycle in a write stage before the destination register is updated at the end of that cycle. Each instruction names a destination, two sources and a small unsigned immediate. It computes `dst = src_a + src_b + imm` modulo 2^DW.

The issue logic compares both source indices with the destinations of every instruction still in flight. While a match sits in either execution stage, `iss_ready` is low and the instruction is held. A match in the write stage does not stall. The operand is instead taken straight from the write-stage result, so a dependent instruction starts exactly one cycle earlier than it could by reading the bank. Independent instructions issue one per cycle. A registered debug port reads any register one cycle after its address is presented.

Top module: `rxb_core`

## Requirements
- R1: After reset every register reads zero, no instruction is in flight and `iss_ready` is high.
- R2: An instruction accepted at clock edge E updates its destination at edge E+3. A debug read whose address is held from E onward returns the old value after edge E+3 and the new value after edge E+4.
- R3: The result written is `src_a + src_b + imm` with `imm` zero-extended, truncated to DW bits (wraps modulo 2^DW).
- R4: Instructions whose sources match no in-flight destination are accepted on consecutive edges, one per cycle.
- R5: While a source index equals the destination of an instruction in either execution stage, `iss_ready` is low and the instruction is not accepted. A consumer requested right after its producer sees exactly two stalled cycles.
- R6: A source that matches the write-stage destination takes the write-stage result through the bypass. A consumer requested right after its producer is therefore accepted exactly three edges after the producer.
- R7: When both sources match the write-stage destination, both operands take the bypassed value.
- R8: A consumer accepted one or more cycles after the producer's write cycle reads the bank, sees no stall and gets the written value.
- R9: Register 0 is an ordinary register. It can be written and read back with non-zero values.
- R10: The value a consumer receives through the bypass equals the value written to the bank in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction is offered |
| iss_dst | input | $clog2(NREGS) | Destination register index |
| iss_src_a | input | $clog2(NREGS) | First source register index |
| iss_src_b | input | $clog2(NREGS) | Second source register index |
| iss_imm | input | IW | Unsigned immediate added to the sum |
| iss_ready | output | 1 | High when the offered instruction is accepted at the next edge |
| dbg_addr | input | $clog2(NREGS) | Debug read index |
| dbg_data | output | DW | Registered debug read data |

## Verification
The bench builds the block with four registers, an 8-bit datapath and a 4-bit immediate. With only four registers, random streams hit read-after-write hazards constantly, and a source often matches both an execution stage and the write stage. The 8-bit width makes sums wrap after a few additions, so truncation is exercised without long chains. Directed sequences measure stall counts and issue gaps for a producer followed at once by a consumer, for a double-source bypass and for a consumer that arrives after the write.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  localparam int NUM_SRC = 2;

  typedef enum logic {
    SRC_BANK   = 1'b0,
    SRC_BYPASS = 1'b1
  } opsrc_e;
endpackage

// File: rtl/rxb_regbank.sv
module rxb_regbank #(
  parameter int NREGS = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(NREGS),
  localparam int NS   = rxb_pkg::NUM_SRC
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [DW-1:0]          wr_data,
  input  logic [NS-1:0][AW-1:0]  rd_addr,
  output logic [NS-1:0][DW-1:0]  rd_data,
  input  logic [AW-1:0]          dbg_addr,
  output logic [DW-1:0]          dbg_data
);
  logic [DW-1:0] mem [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dbg_data <= '0;
    else     dbg_data <= mem[dbg_addr];
  end

  for (genvar g = 0; g < NS; g++) begin : g_rd
    assign rd_data[g] = mem[rd_addr[g]];
  end
endmodule

// File: rtl/rxb_hazard.sv
module rxb_hazard #(
  parameter int AW  = 4,
  localparam int NS = rxb_pkg::NUM_SRC
) (
  input  logic [NS-1:0][AW-1:0]          src,
  input  logic                           ex1_valid,
  input  logic [AW-1:0]                  ex1_dst,
  input  logic                           ex2_valid,
  input  logic [AW-1:0]                  ex2_dst,
  input  logic                           wb_valid,
  input  logic [AW-1:0]                  wb_dst,
  output logic                           stall,
  output rxb_pkg::opsrc_e [NS-1:0]       sel
);
  logic [NS-1:0] hit_ex;

  for (genvar g = 0; g < NS; g++) begin : g_src
    assign hit_ex[g] = (ex1_valid && src[g] == ex1_dst) ||
                       (ex2_valid && src[g] == ex2_dst);
    assign sel[g]    = (wb_valid && src[g] == wb_dst) ? rxb_pkg::SRC_BYPASS
                                                      : rxb_pkg::SRC_BANK;
  end

  assign stall = |hit_ex;
endmodule

// File: rtl/rxb_xbar_rd.sv
module rxb_xbar_rd #(
  parameter int AW  = 4,
  parameter int DW  = 32,
  parameter int IW  = 8,
  localparam int NS = rxb_pkg::NUM_SRC
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      accept,
  input  logic [AW-1:0]             dst,
  input  logic [IW-1:0]             imm,
  input  rxb_pkg::opsrc_e [NS-1:0]  sel,
  input  logic [NS-1:0][DW-1:0]     bank_data,
  input  logic [DW-1:0]             byp_data,
  output logic                      f_valid,
  output logic [AW-1:0]             f_dst,
  output logic [IW-1:0]             f_imm,
  output logic [NS-1:0][DW-1:0]     f_op
);
  logic [NS-1:0][DW-1:0] pick;

  for (genvar g = 0; g < NS; g++) begin : g_mux
    assign pick[g] = (sel[g] == rxb_pkg::SRC_BYPASS) ? byp_data : bank_data[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      f_valid <= 1'b0;
      f_dst   <= '0;
      f_imm   <= '0;
      f_op    <= '0;
    end else begin
      f_valid <= accept;
      if (accept) begin
        f_dst <= dst;
        f_imm <= imm;
        f_op  <= pick;
      end
    end
  end
endmodule

// File: rtl/rxb_alu2.sv
module rxb_alu2 #(
  parameter int AW  = 4,
  parameter int DW  = 32,
  parameter int IW  = 8,
  localparam int NS = rxb_pkg::NUM_SRC
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [AW-1:0]         in_dst,
  input  logic [IW-1:0]         in_imm,
  input  logic [NS-1:0][DW-1:0] in_op,
  output logic                  s1_valid,
  output logic [AW-1:0]         s1_dst,
  output logic                  s2_valid,
  output logic [AW-1:0]         s2_dst,
  output logic [DW-1:0]         s2_data
);
  logic [DW-1:0] s1_sum;
  logic [IW-1:0] s1_imm;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_dst   <= '0;
      s1_sum   <= '0;
      s1_imm   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_dst <= in_dst;
        s1_sum <= in_op[0] + in_op[1];
        s1_imm <= in_imm;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid <= 1'b0;
      s2_dst   <= '0;
      s2_data  <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_dst  <= s1_dst;
        s2_data <= s1_sum + DW'(s1_imm);
      end
    end
  end
endmodule

// File: rtl/rxb_core.sv
module rxb_core #(
  parameter int NREGS = 16,
  parameter int DW    = 32,
  parameter int IW    = 8,
  localparam int AW   = $clog2(NREGS),
  localparam int NS   = rxb_pkg::NUM_SRC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  input  logic [AW-1:0] iss_dst,
  input  logic [AW-1:0] iss_src_a,
  input  logic [AW-1:0] iss_src_b,
  input  logic [IW-1:0] iss_imm,
  output logic          iss_ready,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);
  logic [NS-1:0][AW-1:0]     src;
  logic [NS-1:0][DW-1:0]     bank_rd;
  rxb_pkg::opsrc_e [NS-1:0]  sel;
  logic                      stall, accept;
  logic                      f_valid, s1_valid, wb_valid;
  logic [AW-1:0]             f_dst, s1_dst, wb_dst;
  logic [IW-1:0]             f_imm;
  logic [NS-1:0][DW-1:0]     f_op;
  logic [DW-1:0]             wb_data;

  assign src[0]    = iss_src_a;
  assign src[1]    = iss_src_b;
  assign iss_ready = !stall;
  assign accept    = iss_valid && !stall;

  rxb_hazard #(.AW(AW)) u_haz (
    .src(src), .ex1_valid(f_valid), .ex1_dst(f_dst),
    .ex2_valid(s1_valid), .ex2_dst(s1_dst),
    .wb_valid(wb_valid), .wb_dst(wb_dst),
    .stall(stall), .sel(sel)
  );

  rxb_regbank #(.NREGS(NREGS), .DW(DW)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(wb_valid), .wr_addr(wb_dst), .wr_data(wb_data),
    .rd_addr(src), .rd_data(bank_rd),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  rxb_xbar_rd #(.AW(AW), .DW(DW), .IW(IW)) u_xrd (
    .clk(clk), .rst(rst), .accept(accept),
    .dst(iss_dst), .imm(iss_imm), .sel(sel),
    .bank_data(bank_rd), .byp_data(wb_data),
    .f_valid(f_valid), .f_dst(f_dst), .f_imm(f_imm), .f_op(f_op)
  );

  rxb_alu2 #(.AW(AW), .DW(DW), .IW(IW)) u_alu (
    .clk(clk), .rst(rst),
    .in_valid(f_valid), .in_dst(f_dst), .in_imm(f_imm), .in_op(f_op),
    .s1_valid(s1_valid), .s1_dst(s1_dst),
    .s2_valid(wb_valid), .s2_dst(wb_dst), .s2_data(wb_data)
  );
endmodule

// File: rtl/rxb_chk.sv
module rxb_chk #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          accept,
  input logic          iss_ready,
  input logic [AW-1:0] src_a,
  input logic [AW-1:0] src_b,
  input logic          f_valid,
  input logic [AW-1:0] f_dst,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic          s1_valid,
  input logic [AW-1:0] s1_dst,
  input logic          wb_valid,
  input logic [AW-1:0] wb_dst,
  input logic [DW-1:0] wb_data
);
  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!f_valid && !s1_valid && !wb_valid && iss_ready));

  // R2
  wb_latency_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> ##3 wb_valid);

  // R5
  no_ex_issue_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> !(f_valid && (src_a == f_dst || src_b == f_dst)) &&
               !(s1_valid && (src_a == s1_dst || src_b == s1_dst)));

  // R6 R10
  byp_a_chk: assert property (@(posedge clk) disable iff (rst)
    accept && wb_valid && src_a == wb_dst |=> op_a == $past(wb_data));

  // R7 R10
  byp_b_chk: assert property (@(posedge clk) disable iff (rst)
    accept && wb_valid && src_b == wb_dst |=> op_b == $past(wb_data));

  // R8
  bank_read_chk: assert property (@(posedge clk) disable iff (rst)
    accept && !(wb_valid && src_a == wb_dst) && $past(wb_valid) &&
    src_a == $past(wb_dst) |=> op_a == $past(wb_data, 2));
endmodule

bind rxb_core rxb_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .accept(accept), .iss_ready(iss_ready),
  .src_a(iss_src_a), .src_b(iss_src_b),
  .f_valid(f_valid), .f_dst(f_dst), .op_a(f_op[0]), .op_b(f_op[1]),
  .s1_valid(s1_valid), .s1_dst(s1_dst),
  .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data)
);

// File: tb/sim_rxb_core.sv
`timescale 1ns/100ps
module sim_rxb_core;
  localparam int NREGS = 4;
  localparam int DW    = 8;
  localparam int IW    = 4;
  localparam int AW    = $clog2(NREGS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          iss_valid = 1'b0;
  logic [AW-1:0] iss_dst = '0, iss_src_a = '0, iss_src_b = '0;
  logic [IW-1:0] iss_imm = '0;
  logic          iss_ready;
  logic [AW-1:0] dbg_addr = '0;
  logic [DW-1:0] dbg_data;

  always #2 clk = ~clk;

  rxb_core #(.NREGS(NREGS), .DW(DW), .IW(IW)) u0 (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_dst(iss_dst),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_imm(iss_imm),
    .iss_ready(iss_ready), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [DW-1:0] model [NREGS];

  typedef struct {
    logic [AW-1:0] dst;
    logic [DW-1:0] val;
    int            due;
    string         tag;
  } exp_t;
  exp_t sbq[$];
  exp_t pend;
  bit   pend_v = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input int d, input int a, input int b, input int im,
                       input bit track, input string tag,
                       output int acc, output int stalls);
    logic [DW-1:0] v;
    iss_valid = 1'b1;
    iss_dst   = AW'(d);
    iss_src_a = AW'(a);
    iss_src_b = AW'(b);
    iss_imm   = IW'(im);
    stalls    = 0;
    #1;
    while (!iss_ready) begin
      stalls++;
      @(negedge clk);
    end
    acc = cyc + 1;
    v = model[a] + model[b] + DW'(im);
    model[d] = v;
    if (track) sbq.push_back('{dst: AW'(d), val: v, due: acc + 4, tag: tag});
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  // monitor: pops expected writes and compares the debug read
  initial begin
    forever begin
      @(negedge clk);
      if (pend_v && pend.due == cyc) begin
        check(pend.tag, $sformatf("r%0d value", pend.dst), int'(dbg_data), int'(pend.val));
        pend_v = 0;
      end
      if (sbq.size() > 0 && sbq[0].due == cyc + 1) begin
        pend     = sbq.pop_front();
        pend_v   = 1;
        dbg_addr = pend.dst;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL R4 watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int a0, a1, a2, s0, s1, s2;
    for (int i = 0; i < NREGS; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    check("R1", "ready after reset", int'(iss_ready), 1);
    for (int i = 0; i < NREGS; i++) begin
      dbg_addr = AW'(i);
      @(negedge clk);
      check("R1", $sformatf("r%0d after reset", i), int'(dbg_data), 0);
    end

    // R2: exact write timing, r1 = r0 + r0 + 5
    issue(1, 0, 0, 5, 0, "R2", a0, s0);
    dbg_addr = AW'(1);
    repeat (3) @(negedge clk);
    check("R2", "old value one edge before visibility", int'(dbg_data), 0);
    @(negedge clk);
    check("R2", "new value after write", int'(dbg_data), 5);

    // R4: independent back-to-back issue
    issue(2, 1, 1, 1, 1, "R3", a0, s0);
    issue(3, 1, 0, 2, 1, "R3", a1, s1);
    issue(0, 1, 1, 0, 1, "R9", a2, s2);
    check("R4", "gap 1->2", a1 - a0, 1);
    check("R4", "gap 2->3", a2 - a1, 1);
    check("R4", "stalls", s0 + s1 + s2, 0);

    // R5 R6: dependent pair, consumer requested at once
    issue(1, 2, 3, 0, 1, "R3", a0, s0);
    issue(2, 1, 0, 1, 1, "R6", a1, s1);
    check("R5", "stalled cycles of consumer", s1, 2);
    check("R6", "issue gap with bypass", a1 - a0, 3);

    // R7 R10: both sources bypassed
    issue(3, 1, 2, 4, 1, "R3", a0, s0);
    issue(0, 3, 3, 1, 1, "R7", a1, s1);
    check("R7", "double bypass issue gap", a1 - a0, 3);

    // R8: consumer after write cycle reads the bank; sum wraps (R3)
    issue(2, 0, 1, 9, 1, "R3", a0, s0);
    repeat (3) @(negedge clk);
    issue(1, 2, 2, 0, 1, "R8", a1, s1);
    check("R8", "late consumer stalls", s1, 0);
    check("R8", "late consumer gap", a1 - a0, 4);

    // R9: register 0 as source and destination
    issue(0, 0, 0, 3, 1, "R9", a0, s0);

    // R3 R10: random stream with dense hazards
    for (int k = 0; k < 80; k++) begin
      issue($urandom_range(0, NREGS-1), $urandom_range(0, NREGS-1),
            $urandom_range(0, NREGS-1), $urandom_range(0, (1 << IW) - 1),
            1, "R10", a0, s0);
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    repeat (8) @(negedge clk);
    check("R3", "scoreboard drained", sbq.size() + int'(pend_v), 0);
    finish_run();
  end
endmodule